// File: doc/BRIEF.md
# Interlaced Field Capture Bus Master

This block takes the byte stream of an interlaced video source, already separated into fields by an upstream decoder, and writes it to memory with bus-master bursts. Each field is stored contiguously from one of two programmable start addresses: one for odd fields and one for even fields. A display engine can then alternate between the two regions and show each field in turn, which is bob deinterlacing. The decoder's field flag picks the region without any help from software.

Setting the capture enable does not start a capture at once. Capture begins at the next field boundary, so a field is never stored from its middle. Incoming bytes collect in an internal FIFO, and a fixed-size burst is requested whenever a full burst's worth is waiting. When the next field boundary closes a field, the bytes of that field still in the FIFO go out as one last short burst. Only after that does the block raise a sticky field-complete flag and update a status bit that tells which field has just landed in memory. Software uses the flag to point the display at the finished field. A second sticky flag records bytes that were lost because the FIFO was full.

Top module: `field_capture_dma`

## Requirements
- R1: After reset, `wr_req`, `wr_valid`, `irq`, `ovf` and `stat_odd` are all 0.
- R2: Pixel bytes are discarded until a `fld_start` pulse is seen with `cfg_cap_en` = 1. Bytes that arrive before that pulse never appear on the write interface.
- R3: At each captured field start, the write address is set to `cfg_odd_base` when `fld_odd` = 1 and to `cfg_even_base` when `fld_odd` = 0. Byte k of the field (counting from 0) is written to base + k.
- R4: When no field is being closed, a burst is requested as soon as the FIFO holds BURST (default 32) bytes, with `wr_len` = BURST. Each completed burst advances the address by its length. Bytes leave in the order they arrived.
- R5: When a `fld_start` pulse ends a captured field, the remaining bytes of that field go out in bursts. The last of these has `wr_len` = remainder (1 to BURST−1) when the field length is not a multiple of BURST. The complete flag is not set before the last byte of the field has been written.
- R6: The field-complete flag is set once the final byte of a closed field has been written. It stays set until `irq_clr` = 1. `irq` shows the flag only while `cfg_irq_en` = 1; a flag set while the enable is low appears on `irq` as soon as the enable is raised.
- R7: `stat_odd` changes together with the complete flag and holds 1 when the finished field was odd and 0 when it was even.
- R8: `wr_addr` and `wr_len` stay stable while `wr_req` waits for `wr_gnt`. Data beats (`wr_valid`) come only after the grant, never in the same cycle as a request. `wr_data` holds while `wr_ready` = 0.
- R9: A byte that arrives while capturing with the FIFO full is dropped and sets `ovf`. `ovf` stays set until `ovf_clr` = 1. The bytes already stored are still written normally.
- R10: If `cfg_cap_en` = 0 at a field start, the field that was running still completes and raises the flag, and the field that follows is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cap_en | input | 1 | Capture enable, sampled at field starts |
| cfg_irq_en | input | 1 | Gates the field-complete flag onto `irq` |
| cfg_odd_base | input | AW | Start address of odd fields |
| cfg_even_base | input | AW | Start address of even fields |
| irq_clr | input | 1 | Write-one clear of the field-complete flag |
| ovf_clr | input | 1 | Write-one clear of the overflow flag |
| px_data | input | 8 | Pixel byte |
| px_valid | input | 1 | Pixel byte valid |
| fld_start | input | 1 | One-cycle pulse marking a new field |
| fld_odd | input | 1 | Identity of the new field at `fld_start` (1 = odd) |
| wr_req | output | 1 | Burst request |
| wr_addr | output | AW | Burst start byte address |
| wr_len | output | LEN_W | Burst length in bytes |
| wr_gnt | input | 1 | Burst request accepted |
| wr_data | output | 8 | Burst data byte |
| wr_valid | output | 1 | Burst data valid |
| wr_ready | input | 1 | Memory side accepts a data byte |
| irq | output | 1 | Field-complete interrupt |
| stat_odd | output | 1 | Identity of the last completed field (1 = odd) |
| ovf | output | 1 | Sticky FIFO overflow flag |

## Verification
The assertions assume that the decoder never raises `px_valid` in the same cycle as `fld_start`. They also assume that a new field start never arrives while the previous field's remainder is still draining. CCIR-656 blanking intervals guarantee both in real use. The bench keeps to these rules: it drives each field start on a cycle of its own, then waits until every expected byte of the closed field has been written before it sends the next field's pixels. Random pacing of pixels, grants and ready stays below the write rate, so the FIFO fills only in the directed overflow case, where grants are withheld on purpose.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_REQ  = 2'd1,
    ENG_DATA = 2'd2
  } eng_state_t;
endpackage

// File: rtl/cap_rst_sync.sv
module cap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      meta_q  <= 1'b1;
      rst_q_n <= meta_q;
    end
  end
endmodule

// File: rtl/cap_byte_fifo.sv
module cap_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q, wp_n, rp_n;
  logic [LW-1:0] cnt_q, cnt_n;

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= din;
  end

  always_comb begin
    wp_n  = push ? wp_q + PW'(1) : wp_q;
    rp_n  = pop  ? rp_q + PW'(1) : rp_q;
    cnt_n = cnt_q + LW'(push) - LW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  assign dout  = mem[rp_q];
  assign level = cnt_q;
  assign full  = (cnt_q == LW'(DEPTH));
endmodule

// File: rtl/cap_burst_eng.sv
module cap_burst_eng
  import cap_pkg::*;
#(
  parameter int AW    = 32,
  parameter int BURST = 32,
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH) + 1,
  localparam int LEN_W = $clog2(BURST) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [AW-1:0]    odd_base,
  input  logic [AW-1:0]    even_base,
  input  logic             fld_start,
  input  logic             fld_odd,
  input  logic [LVL_W-1:0] level,
  output logic             pop,
  output logic             run,
  input  logic             wr_gnt,
  input  logic             wr_ready,
  output logic             wr_req,
  output logic [AW-1:0]    wr_addr,
  output logic [LEN_W-1:0] wr_len,
  output logic             wr_valid,
  output logic             done,
  output logic             stat_odd
);
  localparam logic [LVL_W-1:0] BURST_L = LVL_W'(BURST);
  localparam logic [LEN_W-1:0] BURST_N = LEN_W'(BURST);

  eng_state_t       st_q, st_n;
  logic [AW-1:0]    addr_q, addr_n;
  logic [LEN_W-1:0] len_q, len_n, beat_q, beat_n;
  logic [LVL_W-1:0] left_q, left_n;
  logic             closing_q, closing_n, run_q, run_n;
  logic             cur_q, cur_n, nxt_q, nxt_n, stat_q, stat_n;

  assign pop = (st_q == ENG_DATA) && wr_ready;

  always_comb begin
    st_n      = st_q;
    addr_n    = addr_q;
    len_n     = len_q;
    beat_n    = beat_q;
    left_n    = left_q;
    closing_n = closing_q;
    run_n     = run_q;
    cur_n     = cur_q;
    nxt_n     = nxt_q;
    stat_n    = stat_q;
    done      = 1'b0;
    unique case (st_q)
      ENG_IDLE: begin
        if (closing_q && left_q == '0) begin
          done      = 1'b1;
          closing_n = 1'b0;
          stat_n    = cur_q;
          cur_n     = nxt_q;
          addr_n    = nxt_q ? odd_base : even_base;
        end else if (closing_q) begin
          st_n  = ENG_REQ;
          len_n = (left_q >= BURST_L) ? BURST_N : left_q[LEN_W-1:0];
        end else if (level >= BURST_L) begin
          st_n  = ENG_REQ;
          len_n = BURST_N;
        end
      end
      ENG_REQ: begin
        if (wr_gnt) begin
          st_n   = ENG_DATA;
          beat_n = len_q;
        end
      end
      ENG_DATA: begin
        if (wr_ready) begin
          beat_n = beat_q - LEN_W'(1);
          if (beat_q == LEN_W'(1)) begin
            st_n   = ENG_IDLE;
            addr_n = addr_q + AW'(len_q);
          end
        end
      end
      default: st_n = ENG_IDLE;
    endcase
    if (closing_q && pop) left_n = left_q - LVL_W'(1);
    if (fld_start) begin
      run_n = cap_en;
      nxt_n = fld_odd;
      if (run_q) begin
        closing_n = 1'b1;
        left_n    = level - LVL_W'(pop);
      end else if (cap_en) begin
        cur_n  = fld_odd;
        addr_n = fld_odd ? odd_base : even_base;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ENG_IDLE;
      addr_q    <= '0;
      len_q     <= '0;
      beat_q    <= '0;
      left_q    <= '0;
      closing_q <= 1'b0;
      run_q     <= 1'b0;
      cur_q     <= 1'b0;
      nxt_q     <= 1'b0;
      stat_q    <= 1'b0;
    end else begin
      st_q      <= st_n;
      addr_q    <= addr_n;
      len_q     <= len_n;
      beat_q    <= beat_n;
      left_q    <= left_n;
      closing_q <= closing_n;
      run_q     <= run_n;
      cur_q     <= cur_n;
      nxt_q     <= nxt_n;
      stat_q    <= stat_n;
    end
  end

  assign run      = run_q;
  assign wr_req   = (st_q == ENG_REQ);
  assign wr_valid = (st_q == ENG_DATA);
  assign wr_addr  = addr_q;
  assign wr_len   = len_q;
  assign stat_odd = stat_q;
endmodule

// File: rtl/field_capture_dma.sv
module field_capture_dma #(
  parameter int AW    = 32,
  parameter int BURST = 32,
  parameter int DEPTH = 64,
  localparam int LVL_W = $clog2(DEPTH) + 1,
  localparam int LEN_W = $clog2(BURST) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cap_en,
  input  logic             cfg_irq_en,
  input  logic [AW-1:0]    cfg_odd_base,
  input  logic [AW-1:0]    cfg_even_base,
  input  logic             irq_clr,
  input  logic             ovf_clr,
  input  logic [7:0]       px_data,
  input  logic             px_valid,
  input  logic             fld_start,
  input  logic             fld_odd,
  output logic             wr_req,
  output logic [AW-1:0]    wr_addr,
  output logic [LEN_W-1:0] wr_len,
  input  logic             wr_gnt,
  output logic [7:0]       wr_data,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic             irq,
  output logic             stat_odd,
  output logic             ovf
);
  logic             rst_q_n;
  logic             push, pop, full, run, done;
  logic [LVL_W-1:0] level;
  logic             irq_q, irq_n, ovf_q, ovf_n;

  cap_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  assign push = px_valid && run && !full;

  cap_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst_n(rst_q_n), .push(push), .din(px_data), .pop(pop),
    .dout(wr_data), .level(level), .full(full)
  );

  cap_burst_eng #(.AW(AW), .BURST(BURST), .DEPTH(DEPTH)) u_eng (
    .clk(clk), .rst_n(rst_q_n), .cap_en(cfg_cap_en),
    .odd_base(cfg_odd_base), .even_base(cfg_even_base),
    .fld_start(fld_start), .fld_odd(fld_odd), .level(level), .pop(pop),
    .run(run), .wr_gnt(wr_gnt), .wr_ready(wr_ready), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_len(wr_len), .wr_valid(wr_valid),
    .done(done), .stat_odd(stat_odd)
  );

  always_comb begin
    irq_n = done ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
    ovf_n = (px_valid && run && full) ? 1'b1 : (ovf_clr ? 1'b0 : ovf_q);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      irq_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      irq_q <= irq_n;
      ovf_q <= ovf_n;
    end
  end

  assign irq = irq_q && cfg_irq_en;
  assign ovf = ovf_q;
endmodule

// File: rtl/fcap_chk.sv
module fcap_chk #(
  parameter int AW    = 32,
  parameter int BURST = 32,
  localparam int LEN_W = $clog2(BURST) + 1
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             wr_req,
  input logic             wr_gnt,
  input logic [AW-1:0]    wr_addr,
  input logic [LEN_W-1:0] wr_len,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [7:0]       wr_data,
  input logic             irq,
  input logic             irq_clr,
  input logic             cfg_irq_en,
  input logic             ovf,
  input logic             ovf_clr
);
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_req && !wr_gnt |=> wr_req && $stable(wr_addr) && $stable(wr_len));
  // R8
  req_beat_excl_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(wr_req && wr_valid));
  // R8
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));
  // R4
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    wr_req |-> (wr_len != '0) && (wr_len <= LEN_W'(BURST)));
  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    irq && !irq_clr && cfg_irq_en |=> irq);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    ovf && !ovf_clr |=> ovf);
endmodule

bind field_capture_dma fcap_chk #(.AW(AW), .BURST(BURST)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .wr_req(wr_req), .wr_gnt(wr_gnt),
  .wr_addr(wr_addr), .wr_len(wr_len), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_data(wr_data), .irq(irq), .irq_clr(irq_clr),
  .cfg_irq_en(cfg_irq_en), .ovf(ovf), .ovf_clr(ovf_clr)
);

// File: tb/test_field_capture_dma.sv
module test_field_capture_dma;
  localparam int AW = 32, BURST = 32, DEPTH = 64;
  localparam int LEN_W = $clog2(BURST) + 1;
  localparam logic [AW-1:0] ODD_B = 32'h0001_0000, EVEN_B = 32'h0002_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_cap_en = 1'b0, cfg_irq_en = 1'b1, irq_clr = 1'b0, ovf_clr = 1'b0;
  logic [AW-1:0] cfg_odd_base = ODD_B, cfg_even_base = EVEN_B;
  logic [7:0] px_data = '0;
  logic px_valid = 1'b0, fld_start = 1'b0, fld_odd = 1'b0;
  logic wr_req, wr_valid, irq, stat_odd, ovf;
  logic [AW-1:0] wr_addr;
  logic [LEN_W-1:0] wr_len;
  logic [7:0] wr_data;
  logic wr_gnt = 1'b0, wr_ready = 1'b0;

  int checks = 0, errors = 0, beats = 0, kept = 0;
  bit stall = 1'b0, finished = 1'b0;
  logic [AW-1:0] q_addr[$];
  logic [7:0]    q_data[$];
  int            q_fld[$];
  logic [AW-1:0] b_addr;
  int b_len = 0, b_idx = 0, b_fld = 0;
  int fld_id = 0, off = 0;
  bit armed = 1'b0, prev_cap = 1'b0, prev_odd = 1'b0;
  logic [AW-1:0] base = '0;

  always #4 clk = ~clk;

  field_capture_dma #(.AW(AW), .BURST(BURST), .DEPTH(DEPTH)) i_field_capture_dma (
    .clk(clk), .rst_n(rst_n), .cfg_cap_en(cfg_cap_en), .cfg_irq_en(cfg_irq_en),
    .cfg_odd_base(cfg_odd_base), .cfg_even_base(cfg_even_base),
    .irq_clr(irq_clr), .ovf_clr(ovf_clr), .px_data(px_data),
    .px_valid(px_valid), .fld_start(fld_start), .fld_odd(fld_odd),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_len(wr_len), .wr_gnt(wr_gnt),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .irq(irq), .stat_odd(stat_odd), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] field_base(input bit odd);
    return odd ? ODD_B : EVEN_B;
  endfunction

  // memory-side model and monitor: drive at negedge, sample 1 ns later
  always @(negedge clk) begin
    wr_gnt   = !stall && ($urandom % 4 != 0);
    wr_ready = ($urandom % 4 != 0);
    #1;
    if (rst_n && wr_req && wr_gnt) begin
      b_addr = wr_addr; b_len = int'(wr_len); b_idx = 0;
      b_fld = (q_fld.size() > 0) ? q_fld[0] : -1;
    end
    if (rst_n && wr_valid && wr_ready) begin
      beats++;
      if (q_data.size() == 0) begin
        chk(1'b0, "R2", "unexpected beat", longint'(wr_data), 0);
      end else begin
        // R3 address of byte k is base + k ; R4 order kept
        chk(b_addr + AW'(b_idx) == q_addr[0], "R3", "beat address",
            longint'(b_addr + AW'(b_idx)), longint'(q_addr[0]));
        chk(wr_data == q_data[0], "R4", "beat data", longint'(wr_data), longint'(q_data[0]));
        chk(irq == 1'b0, "R5", "irq before last byte", longint'(irq), 0);
        void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_fld.pop_front());
      end
      b_idx++;
      if (b_idx == b_len && b_len < BURST)
        // R5 short burst only as the field's last burst
        chk(q_fld.size() == 0 || q_fld[0] != b_fld, "R5", "short burst mid-field",
            longint'(b_len), BURST);
    end
  end

  task automatic wait_drain();
    for (int i = 0; i < 5000 && q_data.size() > 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic new_field(input bit odd);
    @(negedge clk);
    fld_start = 1'b1; fld_odd = odd;
    @(negedge clk);
    fld_start = 1'b0;
    if (prev_cap) begin
      wait_drain();
      chk(irq == cfg_irq_en, "R6", "irq after field", longint'(irq), longint'(cfg_irq_en));
      chk(stat_odd == prev_odd, "R7", "completed field id", longint'(stat_odd), longint'(prev_odd));
      if (!cfg_irq_en) begin
        cfg_irq_en = 1'b1;
        #1;
        chk(irq == 1'b1, "R6", "irq on late enable", longint'(irq), 1);
      end
      @(negedge clk); irq_clr = 1'b1;
      @(negedge clk); irq_clr = 1'b0;
      @(negedge clk);
      chk(irq == 1'b0, "R6", "irq after clear", longint'(irq), 0);
    end
    armed = cfg_cap_en; prev_cap = cfg_cap_en; prev_odd = odd;
    base = field_base(odd); off = 0; fld_id++;
  endtask

  task automatic send_px(input int n, input int keep_max, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps) repeat ($urandom % 4) @(negedge clk);
      @(negedge clk);
      px_valid = 1'b1; px_data = 8'($urandom);
      if (armed && i < keep_max) begin
        q_addr.push_back(base + AW'(off)); q_data.push_back(px_data);
        q_fld.push_back(fld_id); off++; kept++;
      end
      @(negedge clk);
      px_valid = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    chk(!wr_req && !wr_valid, "R1", "bus idle after reset", longint'({wr_req, wr_valid}), 0);
    chk(irq == 1'b0 && ovf == 1'b0, "R1", "flags after reset", longint'({irq, ovf}), 0);
    chk(stat_odd == 1'b0, "R1", "status after reset", longint'(stat_odd), 0);
    // R2: enabled but not yet armed
    cfg_cap_en = 1'b1;
    send_px(45, 0, 1'b0);
    repeat (20) @(negedge clk);
    chk(beats == 0 && !wr_req, "R2", "no capture before field start", longint'(beats), 0);
    // directed sizes then random fields (R3, R4, R5)
    new_field(1'b1); send_px(64, 1000, 1'b1);
    new_field(1'b0); send_px(1, 1000, 1'b1);
    new_field(1'b1); send_px(33, 1000, 1'b1);
    for (int f = 0; f < 10; f++) begin
      new_field(1'($urandom));
      send_px($urandom_range(1, 150), 1000, 1'b1);
    end
    // R6: flag with interrupt disabled
    cfg_irq_en = 1'b0;
    new_field(1'b0); send_px(40, 1000, 1'b1);
    // R10: capture off at next start, previous field still completes
    cfg_cap_en = 1'b0;
    new_field(1'b1);
    send_px(50, 1000, 1'b1);
    repeat (30) @(negedge clk);
    chk(q_data.size() == 0 && !wr_req && !wr_valid, "R10", "uncaptured field idle",
        longint'(q_data.size()), 0);
    chk(irq == 1'b0, "R10", "no irq for skipped field", longint'(irq), 0);
    // R9: overflow with grants withheld
    cfg_cap_en = 1'b1;
    new_field(1'b1);
    stall = 1'b1;
    send_px(DEPTH + 6, DEPTH, 1'b0);
    repeat (3) @(negedge clk);
    chk(ovf == 1'b1, "R9", "overflow flag", longint'(ovf), 1);
    stall = 1'b0;
    new_field(1'b0);
    chk(q_data.size() == 0, "R9", "stored bytes drained", longint'(q_data.size()), 0);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    @(negedge clk);
    chk(ovf == 1'b0, "R9", "overflow cleared", longint'(ovf), 0);
    send_px(70, 1000, 1'b1);
    cfg_cap_en = 1'b0;
    new_field(1'b1);
    chk(beats == kept, "R4", "total bytes written", longint'(beats), longint'(kept));
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule